// File: doc/BRIEF.md
# Serial Configuration Loader for a Dual Synthesizer

This block takes configuration words from a three-wire serial link and places each one into one of four control registers for a two-channel frequency synthesizer. The three wires are a serial clock, a serial data line and a load strobe. A host shifts a 22-bit word in, most significant bit first. The two bits shifted in last form an address. A rising edge on the load strobe then copies the 20 bits above the address into the register that the address selects.

The three serial inputs come from outside the system clock domain. Each one passes through a two-flop synchronizer, and the edges of the serial clock and of the load strobe are found in the system-clock domain. The block decodes each register into named fields and drives them as outputs. These fields are the divide ratios, the prescaler select, the power-down flags, the charge-pump controls and the output-mode selects for the main channel and the auxiliary channel. The dividers and charge pumps that use these fields are not part of this block.

Top module: `tw_cfg_loader`

## Requirements
- R1: After synchronous active-low reset, every field of all four registers reads zero.
- R2: Each rising edge of the serial clock shifts the synchronized data bit into bit 0 of a 22-bit staging register. Earlier bits move toward bit 21, so the first bit sent ends up at bit 21.
- R3: A rising edge of the load strobe writes staging bits [21:2] into the register selected by staging bits [1:0]. Address 0 selects auxiliary reference, 1 selects auxiliary feedback, 2 selects main reference and 3 selects main feedback. The other three registers keep their values.
- R4: Reference register fields: bits [14:0] are the reference divide ratio, bit 15 is the phase-detector polarity, bit 16 selects 4x pump current, bit 17 forces pump tri-state, and bits [19:18] are the output-mode select.
- R5: Feedback register fields: bits [4:0] are the swallow count, bits [17:5] are the main count, bit 18 selects the prescaler (1 = larger modulus pair), and bit 19 is the channel power-down flag.
- R6: Serial clock edges that occur without a load-strobe rising edge leave every output unchanged. This holds even while the strobe stays high.
- R7: A load-strobe edge after fewer than 22 serial clocks still writes whatever the staging register holds. Bits left over from earlier words remain in the upper positions.
- R8: Shifting and loading keep working while either channel's power-down flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_ld | input | 1 | Load strobe, commits on rising edge |
| aux_ref_div | output | 15 | Auxiliary reference divide ratio |
| aux_pd_pol | output | 1 | Auxiliary phase-detector polarity |
| aux_cp_hi | output | 1 | Auxiliary 4x pump current |
| aux_cp_off | output | 1 | Auxiliary pump tri-state |
| aux_omode | output | 2 | Auxiliary output-mode bits |
| aux_swallow | output | 5 | Auxiliary swallow count |
| aux_count | output | 13 | Auxiliary main count |
| aux_presc | output | 1 | Auxiliary prescaler select |
| aux_pdown | output | 1 | Auxiliary power-down |
| main_ref_div | output | 15 | Main reference divide ratio |
| main_pd_pol | output | 1 | Main phase-detector polarity |
| main_cp_hi | output | 1 | Main 4x pump current |
| main_cp_off | output | 1 | Main pump tri-state |
| main_omode | output | 2 | Main output-mode bits |
| main_swallow | output | 5 | Main swallow count |
| main_count | output | 13 | Main main count |
| main_presc | output | 1 | Main prescaler select |
| main_pdown | output | 1 | Main power-down |

## Verification
A fault in the staging register, such as a dropped, duplicated or misordered bit, stays hidden until the next load strobe. From that strobe on, the committed fields differ from the value the host sent, about three system clocks after the strobe edge. A wrong address decode shows up at the same point, either as a register that does not change or as a neighbouring register that changes when it should not. That is why every output field is compared after every load. A spurious commit, where a register updates with no strobe edge, only shows when the outputs are sampled between loads, so the bench shifts partial words with no strobe and samples the outputs in that gap.

// File: rtl/tw_cfg_pkg.sv
// Package: widths and field layouts shared by the serial config loader.
// Assumes a 22-bit word whose two lowest bits are the register address.
package tw_cfg_pkg;
    parameter int WORD_W   = 22;
    parameter int ADDR_W   = 2;
    parameter int DATA_W   = WORD_W - ADDR_W;
    parameter int NUM_REGS = 1 << ADDR_W;
    parameter int RDIV_W   = 15;
    parameter int MODE_W   = 2;
    parameter int SWAL_W   = 5;
    parameter int CNT_W    = 13;

    // Reference register, MSB first: mode, tri-state, 4x, polarity, divider
    typedef struct packed {
        logic [MODE_W-1:0] omode;
        logic              cp_off;
        logic              cp_hi;
        logic              pd_pol;
        logic [RDIV_W-1:0] div;
    } ref_cfg_t;

    // Feedback register, MSB first: power-down, prescaler, count, swallow
    typedef struct packed {
        logic              pdown;
        logic              presc;
        logic [CNT_W-1:0]  count;
        logic [SWAL_W-1:0] swallow;
    } fb_cfg_t;

    // Register indices set by the address bits
    parameter int IDX_AUX_REF  = 0;
    parameter int IDX_AUX_FB   = 1;
    parameter int IDX_MAIN_REF = 2;
    parameter int IDX_MAIN_FB  = 3;
endpackage

// File: rtl/tw_sync_edge.sv
// Module: tw_sync_edge
// Synchronizes one asynchronous input with STAGES flops. With RISE=1 it
// outputs a one-cycle pulse on each synchronized rising edge; with RISE=0
// it outputs the synchronized level. Assumes the input is steady for
// several system clocks.
module tw_sync_edge #(
    parameter int STAGES = 2,
    parameter bit RISE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    // Synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    generate
        if (RISE) begin : g_rise
            logic last_q;
            // Previous synchronized level, for edge detection
            always_ff @(posedge clk) begin
                if (!rst_n) last_q <= 1'b0;
                else        last_q <= pipe[STAGES-1];
            end
            assign dout = pipe[STAGES-1] & ~last_q;

            AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                dout |=> !dout); // R2
        end else begin : g_level
            assign dout = pipe[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/tw_shift_stage.sv
// Module: tw_shift_stage
// Staging shift register. On each shift pulse it moves left by one bit
// and puts the new bit in bit 0, so the first bit sent ends up at the MSB.
// Assumes shift pulses last one cycle.
module tw_shift_stage #(
    parameter int WIDTH = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    // Shift on each synchronized serial clock edge
    always_ff @(posedge clk) begin
        if (!rst_n)     word <= '0;
        else if (shift) word <= {word[WIDTH-2:0], bit_in};
    end

    AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> word[0] == $past(bit_in)); // R2
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> word[WIDTH-1:1] == $past(word[WIDTH-2:0])); // R2
    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(word)); // R6
endmodule

// File: rtl/tw_reg_bank.sv
// Module: tw_reg_bank
// Four addressed data latches. On a commit pulse, the data field is
// written into the latch the address selects. Assumes commit is a
// single-cycle pulse.
module tw_reg_bank
    import tw_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] regs [NUM_REGS]
);
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_latch
            // Capture the data field when this latch is addressed
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (commit && (addr == ADDR_W'(g)))
                    regs[g] <= data;
            end

            AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !commit |=> $stable(regs[g])); // R6
            AST_LATCH_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
                (commit && addr != ADDR_W'(g)) |=> $stable(regs[g])); // R3
            AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
                (commit && addr == ADDR_W'(g)) |=> regs[g] == $past(data)); // R3
        end
    endgenerate
endmodule

// File: rtl/tw_cfg_loader.sv
// Module: tw_cfg_loader
// Three-wire configuration loader for a two-channel synthesizer. It
// synchronizes the serial inputs, stages the word, commits it on a
// load-strobe edge and decodes the four registers into fields. Assumes
// each serial level is held for at least three system clocks and that
// data is settled before the serial clock rises.
module tw_cfg_loader
    import tw_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_ld,
    output logic [RDIV_W-1:0] aux_ref_div,
    output logic              aux_pd_pol,
    output logic              aux_cp_hi,
    output logic              aux_cp_off,
    output logic [MODE_W-1:0] aux_omode,
    output logic [SWAL_W-1:0] aux_swallow,
    output logic [CNT_W-1:0]  aux_count,
    output logic              aux_presc,
    output logic              aux_pdown,
    output logic [RDIV_W-1:0] main_ref_div,
    output logic              main_pd_pol,
    output logic              main_cp_hi,
    output logic              main_cp_off,
    output logic [MODE_W-1:0] main_omode,
    output logic [SWAL_W-1:0] main_swallow,
    output logic [CNT_W-1:0]  main_count,
    output logic              main_presc,
    output logic              main_pdown
);
    logic              shift_p, dat_s, ld_p;
    logic [WORD_W-1:0] stage;
    logic [DATA_W-1:0] regs [NUM_REGS];
    ref_cfg_t          aux_r, main_r;
    fb_cfg_t           aux_f, main_f;

    tw_sync_edge #(.STAGES(2), .RISE(1'b1)) u_clk_sync (
        .clk(clk), .rst_n(rst_n), .din(ser_clk), .dout(shift_p));
    tw_sync_edge #(.STAGES(2), .RISE(1'b0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .din(ser_dat), .dout(dat_s));
    tw_sync_edge #(.STAGES(2), .RISE(1'b1)) u_ld_sync (
        .clk(clk), .rst_n(rst_n), .din(ser_ld), .dout(ld_p));

    tw_shift_stage #(.WIDTH(WORD_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .shift(shift_p), .bit_in(dat_s), .word(stage));

    tw_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n), .commit(ld_p),
        .addr(stage[ADDR_W-1:0]), .data(stage[WORD_W-1:ADDR_W]), .regs(regs));

    // Map raw latches onto their field layouts
    always_comb begin
        aux_r  = ref_cfg_t'(regs[IDX_AUX_REF]);
        aux_f  = fb_cfg_t'(regs[IDX_AUX_FB]);
        main_r = ref_cfg_t'(regs[IDX_MAIN_REF]);
        main_f = fb_cfg_t'(regs[IDX_MAIN_FB]);
    end

    assign aux_ref_div  = aux_r.div;
    assign aux_pd_pol   = aux_r.pd_pol;
    assign aux_cp_hi    = aux_r.cp_hi;
    assign aux_cp_off   = aux_r.cp_off;
    assign aux_omode    = aux_r.omode;
    assign aux_swallow  = aux_f.swallow;
    assign aux_count    = aux_f.count;
    assign aux_presc    = aux_f.presc;
    assign aux_pdown    = aux_f.pdown;
    assign main_ref_div = main_r.div;
    assign main_pd_pol  = main_r.pd_pol;
    assign main_cp_hi   = main_r.cp_hi;
    assign main_cp_off  = main_r.cp_off;
    assign main_omode   = main_r.omode;
    assign main_swallow = main_f.swallow;
    assign main_count   = main_f.count;
    assign main_presc   = main_f.presc;
    assign main_pdown   = main_f.pdown;

    AST_LD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_p |=> !ld_p); // R3
endmodule

// File: tb/tw_cfg_loader_bench.sv
// Bench for tw_cfg_loader: directed corner cases plus seeded random words,
// checked against a bench-side model of the staging and register behaviour.
module tw_cfg_loader_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;

    logic [14:0] aux_ref_div, main_ref_div;
    logic        aux_pd_pol, aux_cp_hi, aux_cp_off, aux_presc, aux_pdown;
    logic        main_pd_pol, main_cp_hi, main_cp_off, main_presc, main_pdown;
    logic [1:0]  aux_omode, main_omode;
    logic [4:0]  aux_swallow, main_swallow;
    logic [12:0] aux_count, main_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [21:0] m_stage = '0;
    logic [19:0] m_reg [4] = '{default: '0};

    localparam int PH = 4;   // system clocks per serial phase

    always #4 clk = ~clk;    // 125 MHz

    tw_cfg_loader u_tw_cfg_loader (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_ld(ser_ld),
        .aux_ref_div(aux_ref_div), .aux_pd_pol(aux_pd_pol), .aux_cp_hi(aux_cp_hi),
        .aux_cp_off(aux_cp_off), .aux_omode(aux_omode), .aux_swallow(aux_swallow),
        .aux_count(aux_count), .aux_presc(aux_presc), .aux_pdown(aux_pdown),
        .main_ref_div(main_ref_div), .main_pd_pol(main_pd_pol), .main_cp_hi(main_cp_hi),
        .main_cp_off(main_cp_off), .main_omode(main_omode), .main_swallow(main_swallow),
        .main_count(main_count), .main_presc(main_presc), .main_pdown(main_pdown));

    // R4 layout: {omode[1:0], tri, 4x, pol, div[14:0]}
    function automatic logic [19:0] pack_ref(logic [1:0] m, logic t, logic h, logic p, logic [14:0] d);
        return {m, t, h, p, d};
    endfunction
    // R5 layout: {pdown, presc, count[12:0], swallow[4:0]}
    function automatic logic [19:0] pack_fb(logic pd, logic ps, logic [12:0] c, logic [4:0] s);
        return {pd, ps, c, s};
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    // R2: send one bit, MSB-first order is up to the caller
    task automatic send_bit(logic b);
        ser_dat = b;
        wait_clk(PH);
        ser_clk = 1'b1;
        wait_clk(PH);
        ser_clk = 1'b0;
        wait_clk(PH);
        m_stage = {m_stage[20:0], b};
    endtask

    task automatic send_bits(logic [21:0] w, int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    // R3: load strobe pulse, model commits staging bits
    task automatic strobe();
        ser_ld = 1'b1;
        wait_clk(PH);
        ser_ld = 1'b0;
        wait_clk(PH);
        m_reg[m_stage[1:0]] = m_stage[21:2];
    endtask

    task automatic chk(string tag, logic [19:0] act, logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " R4 aux ref"}, pack_ref(aux_omode, aux_cp_off, aux_cp_hi, aux_pd_pol, aux_ref_div), m_reg[0]);
        chk({tag, " R5 aux fb"}, pack_fb(aux_pdown, aux_presc, aux_count, aux_swallow), m_reg[1]);
        chk({tag, " R4 main ref"}, pack_ref(main_omode, main_cp_off, main_cp_hi, main_pd_pol, main_ref_div), m_reg[2]);
        chk({tag, " R5 main fb"}, pack_fb(main_pdown, main_presc, main_count, main_swallow), m_reg[3]);
    endtask

    task automatic write_word(logic [1:0] a, logic [19:0] d, string tag);
        send_bits({d, a}, 22);
        strobe();
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        check_all("R1 reset");

        // R3: one write per address, distinct patterns
        write_word(2'd0, 20'hA5A5A, "R3 addr0");
        write_word(2'd1, 20'h3C3C3, "R3 addr1");
        write_word(2'd2, 20'hF0F0F, "R3 addr2");
        write_word(2'd3, 20'h12345, "R3 addr3");

        // R4: single-field walking bits on main reference
        write_word(2'd2, pack_ref(2'b10, 1'b0, 1'b1, 1'b0, 15'h7FFF), "R4 fields");
        write_word(2'd0, pack_ref(2'b01, 1'b1, 1'b0, 1'b1, 15'd2), "R4 fields");
        // R5: max counts and flags
        write_word(2'd3, pack_fb(1'b0, 1'b1, 13'h1FFF, 5'd31), "R5 fields");
        write_word(2'd1, pack_fb(1'b1, 1'b0, 13'd3, 5'd0), "R5 fields");

        // R6: shifting with no strobe leaves outputs alone
        send_bits(22'h2AAAAB, 22);
        check_all("R6 no strobe");
        // R6: strobe held high while shifting does not re-commit
        ser_ld = 1'b1;
        wait_clk(PH);
        m_reg[m_stage[1:0]] = m_stage[21:2];
        check_all("R6 strobe rise");
        send_bits(22'h155552, 22);
        check_all("R6 strobe held");
        ser_ld = 1'b0;
        wait_clk(PH);
        check_all("R6 strobe fall");

        // R7: short word keeps older bits in the upper positions
        send_bits(22'h0000_1E, 5);
        strobe();
        check_all("R7 short word");
        send_bits(22'h3, 2);
        strobe();
        check_all("R7 two bits");

        // R8: both channels powered down, loader keeps working
        write_word(2'd3, pack_fb(1'b1, 1'b1, 13'd100, 5'd7), "R8 main pdown");
        write_word(2'd1, pack_fb(1'b1, 1'b0, 13'd50, 5'd3), "R8 aux pdown");
        write_word(2'd2, pack_ref(2'b11, 1'b1, 1'b1, 1'b1, 15'd999), "R8 load while down");
        write_word(2'd0, pack_ref(2'b00, 1'b0, 1'b0, 1'b0, 15'd12), "R8 load while down");

        // Random words, random addresses
        for (int i = 0; i < 40; i++) begin
            logic [1:0]  ra;
            logic [19:0] rd;
            ra = 2'($urandom_range(0, 3));
            rd = 20'($urandom());
            write_word(ra, rd, "R3 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule